// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

A 64-entry, 36-bit first-in first-out buffer that joins a producer on one free-running clock with a consumer on another. The two clocks may be unrelated or may be the same net. A transfer on either side takes place at a rising edge only when that side's active-low select is low and its enable is high. A read moves the oldest stored word into an output register, and that register holds its value until the next read.

Four active-low status flags report the fill level. The full and almost-full flags belong to the write clock. The empty and almost-empty flags belong to the read clock. Each pointer is Gray-coded and passes through a two-flop synchronizer into the other domain, so a flag reacts to activity on the far side two edges late and always errs on the safe side. The almost threshold X is picked from four preset values while reset is asserted, and it keeps that value until the next reset.

Top module: `dual_clk_fifo`

## Requirements
- R1: Words leave through `r_data` in the order in which they were accepted, with all 36 bits intact, and up to 64 words can be stored.
- R2: A write is accepted only at a rising `wclk` edge with `w_cs_n`=0 and `w_en`=1. A read is accepted only at a rising `rclk` edge with `r_cs_n`=0 and `r_en`=1. Every other combination leaves the stored contents unchanged.
- R3: `empty_n` is 0 during reset and stays 0 while nothing is stored. A read attempted while `empty_n`=0 is ignored: `r_data` holds its value and no word is consumed.
- R4: After a word is written into an empty FIFO, `empty_n` rises after the second rising `rclk` edge that follows the write edge. This also applies when a read empties the FIFO in the same edge as the write.
- R5: `full_n` is 0 during reset, is still 0 after the first `wclk` edge following the release of reset, and is 1 after the second.
- R6: Once 64 words are held, `full_n` is 0 and further writes are ignored. A word offered while full never appears at the output.
- R7: `aempty_n` is 0 whenever the stored count, as seen in the read domain, is less than or equal to X.
- R8: `afull_n` is 0 whenever the free space (64 minus the count, as seen in the write domain) is less than or equal to X. It reacts to a write in the write edge itself.
- R9: X is 4 << `ofs_sel`, giving 4, 8, 16 or 32 for codes 00, 01, 10 and 11. The code is sampled while `rst_n` is low. Changes to `ofs_sel` after reset has been released have no effect.
- R10: A read frees space as seen by the write side after the second `wclk` edge that follows the read edge, so `full_n` returns to 1 at that point.
- R11: `r_data` is 0 after reset and changes only on an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock, free-running |
| rclk | input | 1 | Read-side clock, free-running |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| ofs_sel | input | 2 | Almost-flag threshold code, sampled during reset |
| w_cs_n | input | 1 | Write select, active low |
| w_en | input | 1 | Write enable, active high |
| w_data | input | 36 | Word to store |
| full_n | output | 1 | Low when no space is free (write clock) |
| afull_n | output | 1 | Low when free space is at most X (write clock) |
| r_cs_n | input | 1 | Read select, active low |
| r_en | input | 1 | Read enable, active high |
| r_data | output | 36 | Output register holding the last word read |
| empty_n | output | 1 | Low when no word is readable (read clock) |
| aempty_n | output | 1 | Low when the stored count is at most X (read clock) |

## Verification
A write and a read can land on the same edge when the clocks coincide. The bench provokes this with one word stored: it writes a new word and reads the old one at the same edge. The check is that `r_data` shows the old word, that `empty_n` drops at once because the new word has not yet crossed, and that `empty_n` rises two read edges later, after which the new word is read. A read that reopens a full FIFO is judged the same way from the write side, by watching `full_n` stay low for exactly one more edge.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  // binary to reflected Gray code
  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // reflected Gray code back to binary
  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // almost-flag threshold from the two-bit select code
  function automatic logic [31:0] offset_for(input logic [1:0] sel, input logic [31:0] base);
    return base << sel;
  endfunction

endpackage

// File: rtl/dcf_sync2.sv
module dcf_sync2 #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/dcf_wside.sv
module dcf_wside
  import dcf_pkg::*;
#(
  parameter int AW       = 6,
  parameter int BASE_OFS = 4
) (
  input  logic        wclk,
  input  logic        rst_n,
  input  logic [1:0]  sel,
  input  logic        cs_n,
  input  logic        en,
  input  logic [AW:0] rgray_s,
  output logic [AW:0] wgray,
  output logic [AW-1:0] waddr,
  output logic        wr_fire,
  output logic        full_n,
  output logic        afull_n
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] DEPTH_W = PW'(DEPTH);

  logic [PW-1:0] wbin_q, wbin_nx, wgray_q, rbin_s, words, free, ofs;
  logic [1:0]    sel_q, rdy_q;

  // threshold code follows the pin only while reset is held
  always_ff @(posedge wclk) begin
    if (!rst_n) sel_q <= sel;
  end

  assign ofs     = PW'(offset_for(sel_q, 32'(BASE_OFS)));
  assign rbin_s  = PW'(gray2bin(32'(rgray_s)));
  assign words   = wbin_q - rbin_s;
  assign free    = DEPTH_W - words;
  assign full_n  = rdy_q[1] & (words != DEPTH_W);
  assign afull_n = (free > ofs);
  assign wr_fire = ~cs_n & en & full_n;
  assign wbin_nx = wbin_q + PW'(wr_fire);

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      rdy_q   <= '0;
    end else begin
      rdy_q   <= {rdy_q[0], 1'b1};
      wbin_q  <= wbin_nx;
      wgray_q <= PW'(bin2gray(32'(wbin_nx)));
    end
  end

  assign wgray = wgray_q;
  assign waddr = wbin_q[AW-1:0];

  // R6
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    words <= DEPTH_W);
  // R8
  full_afull_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (rdy_q[1] && !full_n) |-> !afull_n);
  // R10
  wgray_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);
  // R9
  wofs_hold_chk: assert property (@(posedge wclk) disable iff (!rst_n || !rdy_q[1])
    $stable(sel_q));
endmodule

// File: rtl/dcf_rside.sv
module dcf_rside
  import dcf_pkg::*;
#(
  parameter int AW       = 6,
  parameter int BASE_OFS = 4
) (
  input  logic        rclk,
  input  logic        rst_n,
  input  logic [1:0]  sel,
  input  logic        cs_n,
  input  logic        en,
  input  logic [AW:0] wgray_s,
  output logic [AW:0] rgray,
  output logic [AW-1:0] raddr,
  output logic        rd_fire,
  output logic        empty_n,
  output logic        aempty_n
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] DEPTH_W = PW'(DEPTH);

  logic [PW-1:0] rbin_q, rbin_nx, rgray_q, wbin_s, words, ofs;
  logic [1:0]    sel_q;
  logic          run_q;

  always_ff @(posedge rclk) begin
    if (!rst_n) sel_q <= sel;
  end

  assign ofs      = PW'(offset_for(sel_q, 32'(BASE_OFS)));
  assign wbin_s   = PW'(gray2bin(32'(wgray_s)));
  assign words    = wbin_s - rbin_q;
  assign empty_n  = (words != '0);
  assign aempty_n = (words > ofs);
  assign rd_fire  = ~cs_n & en & empty_n;
  assign rbin_nx  = rbin_q + PW'(rd_fire);

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      run_q   <= 1'b0;
    end else begin
      run_q   <= 1'b1;
      rbin_q  <= rbin_nx;
      rgray_q <= PW'(bin2gray(32'(rbin_nx)));
    end
  end

  assign rgray = rgray_q;
  assign raddr = rbin_q[AW-1:0];

  // R3
  no_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    words <= DEPTH_W);
  // R7
  empty_aempty_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);
  // R4
  rgray_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    $countones(rgray_q ^ $past(rgray_q)) <= 1);
  // R9
  rofs_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n || !run_q)
    $stable(sel_q));
endmodule

// File: rtl/dual_clk_fifo.sv
module dual_clk_fifo #(
  parameter int DW       = 36,
  parameter int AW       = 6,
  parameter int BASE_OFS = 4
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic [1:0]    ofs_sel,
  input  logic          w_cs_n,
  input  logic          w_en,
  input  logic [DW-1:0] w_data,
  output logic          full_n,
  output logic          afull_n,
  input  logic          r_cs_n,
  input  logic          r_en,
  output logic [DW-1:0] r_data,
  output logic          empty_n,
  output logic          aempty_n
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0] waddr, raddr;
  logic          wr_fire, rd_fire;
  logic [DW-1:0] mem [DEPTH];

  dcf_wside #(.AW(AW), .BASE_OFS(BASE_OFS)) u_wside (
    .wclk(wclk), .rst_n(rst_n), .sel(ofs_sel), .cs_n(w_cs_n), .en(w_en),
    .rgray_s(rgray_s), .wgray(wgray), .waddr(waddr), .wr_fire(wr_fire),
    .full_n(full_n), .afull_n(afull_n));

  dcf_rside #(.AW(AW), .BASE_OFS(BASE_OFS)) u_rside (
    .rclk(rclk), .rst_n(rst_n), .sel(ofs_sel), .cs_n(r_cs_n), .en(r_en),
    .wgray_s(wgray_s), .rgray(rgray), .raddr(raddr), .rd_fire(rd_fire),
    .empty_n(empty_n), .aempty_n(aempty_n));

  dcf_sync2 #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
  dcf_sync2 #(.W(PW)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

  always_ff @(posedge wclk) begin
    if (wr_fire) mem[waddr] <= w_data;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)       r_data <= '0;
    else if (rd_fire) r_data <= mem[raddr];
  end

  // R11
  rdata_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    !rd_fire |=> $stable(r_data));
endmodule

// File: tb/test_dual_clk_fifo.sv
module test_dual_clk_fifo;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, w_cs_n, w_en, r_cs_n, r_en;
  logic [1:0]  ofs_sel;
  logic [35:0] w_data, r_data;
  logic        full_n, afull_n, empty_n, aempty_n;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  // fields: {cs_n, en, accepted, data}
  localparam logic [38:0] VEC [8] = '{
    {1'b0, 1'b1, 1'b1, 36'h0_1111_1111},
    {1'b1, 1'b1, 1'b0, 36'hB_AD00_0001},
    {1'b0, 1'b0, 1'b0, 36'hB_AD00_0002},
    {1'b0, 1'b1, 1'b1, 36'h8_0000_0001},
    {1'b1, 1'b0, 1'b0, 36'hB_AD00_0003},
    {1'b0, 1'b1, 1'b1, 36'hF_FFFF_FFFF},
    {1'b0, 1'b1, 1'b1, 36'h0_0000_0000},
    {1'b0, 1'b1, 1'b1, 36'h5_A5A5_A5A5}
  };

  dual_clk_fifo i_dual_clk_fifo (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .ofs_sel(ofs_sel),
    .w_cs_n(w_cs_n), .w_en(w_en), .w_data(w_data),
    .full_n(full_n), .afull_n(afull_n),
    .r_cs_n(r_cs_n), .r_en(r_en), .r_data(r_data),
    .empty_n(empty_n), .aempty_n(aempty_n));

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr1(input logic cs, input logic e, input logic [35:0] d);
    w_cs_n = cs; w_en = e; w_data = d;
    @(negedge clk);
    w_cs_n = 1'b1; w_en = 1'b0;
  endtask

  task automatic rd1(input logic cs, input logic e);
    r_cs_n = cs; r_en = e;
    @(negedge clk);
    r_cs_n = 1'b1; r_en = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] s);
    rst_n = 1'b0; ofs_sel = s;
    tick(3);
    chk("R3 empty_n in reset", 36'(empty_n), 36'd0);
    chk("R5 full_n in reset", 36'(full_n), 36'd0);
    chk("R11 r_data in reset", r_data, 36'd0);
    chk("R7 aempty_n in reset", 36'(aempty_n), 36'd0);
    rst_n = 1'b1;
    tick(1);
    chk("R5 full_n after first edge", 36'(full_n), 36'd0);
    tick(1);
    chk("R5 full_n after second edge", 36'(full_n), 36'd1);
    chk("R8 afull_n when empty", 36'(afull_n), 36'd1);
  endtask

  function automatic logic [35:0] pat(input int i);
    return 36'h3_0000_0000 + 36'(i);
  endfunction

  initial begin
    rst_n = 1'b0; ofs_sel = 2'b00;
    w_cs_n = 1'b1; w_en = 1'b0; w_data = '0;
    r_cs_n = 1'b1; r_en = 1'b0;

    // vector table: select/enable qualification and ordering
    do_reset(2'b00);
    for (int i = 0; i < 8; i++) wr1(VEC[i][38], VEC[i][37], VEC[i][35:0]);
    tick(3);
    chk("R4 empty_n after table writes", 36'(empty_n), 36'd1);
    rd1(1'b1, 1'b1);
    chk("R2 read with cs_n high", r_data, 36'd0);
    rd1(1'b0, 1'b0);
    chk("R11 read with en low", r_data, 36'd0);
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][36]) begin
        rd1(1'b0, 1'b1);
        chk("R1 table order", r_data, VEC[i][35:0]);
      end
    end
    chk("R2 rejected writes not stored", 36'(empty_n), 36'd0);
    rd1(1'b0, 1'b1);
    chk("R3 read while empty holds data", r_data, 36'h5_A5A5_A5A5);

    // empty deassert latency, then write and read on the same edge
    wr1(1'b0, 1'b1, 36'h0_CAFE_0001);
    chk("R4 empty_n at write edge", 36'(empty_n), 36'd0);
    tick(1);
    chk("R4 empty_n one edge later", 36'(empty_n), 36'd0);
    tick(1);
    chk("R4 empty_n two edges later", 36'(empty_n), 36'd1);
    w_cs_n = 1'b0; w_en = 1'b1; w_data = 36'h0_CAFE_0002;
    r_cs_n = 1'b0; r_en = 1'b1;
    @(negedge clk);
    w_cs_n = 1'b1; w_en = 1'b0; r_cs_n = 1'b1; r_en = 1'b0;
    chk("R1 same-edge read data", r_data, 36'h0_CAFE_0001);
    chk("R4 empty_n after same-edge", 36'(empty_n), 36'd0);
    tick(1);
    chk("R4 same-edge one later", 36'(empty_n), 36'd0);
    tick(1);
    chk("R4 same-edge two later", 36'(empty_n), 36'd1);
    rd1(1'b0, 1'b1);
    chk("R1 same-edge written word", r_data, 36'h0_CAFE_0002);

    // fill and drain with X = 4; select changed after reset
    do_reset(2'b00);
    ofs_sel = 2'b11;
    for (int i = 0; i < 4; i++) wr1(1'b0, 1'b1, pat(i));
    tick(3);
    chk("R7 aempty_n at count 4", 36'(aempty_n), 36'd0);
    wr1(1'b0, 1'b1, pat(4));
    tick(2);
    chk("R9 aempty_n at count 5, select change ignored", 36'(aempty_n), 36'd1);
    for (int i = 5; i < 59; i++) wr1(1'b0, 1'b1, pat(i));
    chk("R8 afull_n at count 59", 36'(afull_n), 36'd1);
    wr1(1'b0, 1'b1, pat(59));
    chk("R8 afull_n at count 60", 36'(afull_n), 36'd0);
    for (int i = 60; i < 63; i++) wr1(1'b0, 1'b1, pat(i));
    chk("R6 full_n at count 63", 36'(full_n), 36'd1);
    wr1(1'b0, 1'b1, pat(63));
    chk("R6 full_n at count 64", 36'(full_n), 36'd0);
    wr1(1'b0, 1'b1, 36'hD_EAD0_DEAD);
    chk("R6 full_n after extra write", 36'(full_n), 36'd0);
    tick(3);
    rd1(1'b0, 1'b1);
    chk("R1 first word out", r_data, pat(0));
    chk("R10 full_n at read edge", 36'(full_n), 36'd0);
    tick(1);
    chk("R10 full_n one edge later", 36'(full_n), 36'd0);
    tick(1);
    chk("R10 full_n two edges later", 36'(full_n), 36'd1);
    chk("R8 afull_n with one free", 36'(afull_n), 36'd0);
    for (int i = 1; i < 64; i++) begin
      rd1(1'b0, 1'b1);
      chk("R1 drain order", r_data, pat(i));
    end
    chk("R6 empty after 64 reads", 36'(empty_n), 36'd0);
    rd1(1'b0, 1'b1);
    chk("R3 read while empty ignored", r_data, pat(63));
    wr1(1'b0, 1'b1, 36'h1_2345_6789);
    tick(3);
    rd1(1'b0, 1'b1);
    chk("R6 word offered while full never read", r_data, 36'h1_2345_6789);

    // remaining threshold codes
    for (int s = 1; s < 4; s++) begin
      do_reset(2'(s));
      for (int j = 0; j < (4 << s); j++) wr1(1'b0, 1'b1, pat(j));
      tick(3);
      chk("R9 aempty_n at count X", 36'(aempty_n), 36'd0);
      wr1(1'b0, 1'b1, pat(99));
      tick(1);
      chk("R7 aempty_n lag", 36'(aempty_n), 36'd0);
      tick(1);
      chk("R9 aempty_n at count X+1", 36'(aempty_n), 36'd1);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all R) actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule